// File: doc/BRIEF.md
# Watchdog Timer with Pretimeout Interrupt

This block is a watchdog peripheral run by a slow time-base strobe. Each strobe is one half-second step. Software programs a timeout and sets the enable bit. After that the timer runs down and cannot be stopped. Software keeps it alive by writing a fixed two-word key sequence to the service register. If software stops doing this, the timer expires. On expiry the block asserts either the internal chip reset or the external reset pin, as the reset-type bit selects, and it records that a timeout caused the reset. An interrupt can fire a programmable number of half-second steps before expiry. Software can also raise a reset directly through control bits.

Two more features are included. A write-once suspend bit lets a low-power input freeze the count. A power-down counter starts at reset and pulses its own output low for one clock, unless software disables it first.

All access goes through a single 16-bit register port. Writes take one clock. Reads are combinational from the address.

Top module: `wdog_timer`

## Requirements
- R1: Registers are 16 bits wide, at byte offsets 0x0 (control), 0x2 (service, reads 0), 0x4 (cause), 0x6 (interrupt control) and 0x8 (power-down). Any other offset reads 0. Control reads {timeout[15:8], 2'b0, ext_ctl[5], sw_ctl[4], rtype[3], enable[2], 1'b0, suspend[0]}. After reset, control reads 0x0030 and power-down reads 0x0001.
- R2: A control write that sets enable (bit 2) loads a count of timeout+1 half-second steps from the written timeout field. When that count is used up, the block expires. With rtype=0, expiry holds chip_rst high until reset.
- R3: The counter reloads only when 0x5555 is written to the service register and 0xAAAA is the next service write. Any other service write returns the checker to waiting for 0x5555 and does not reload the counter.
- R4: Once enable is set, a control write with bit 2 clear does not stop the timer.
- R5: The suspend bit takes the value of bit 0 on the first control write after reset and ignores all later writes. While suspend and lp_mode are both 1, strobes do not advance the counter.
- R6: With rtype=1, expiry drives ext_rst_n low and leaves chip_rst low.
- R7: sw_ctl=0 asserts chip_rst. ext_ctl=0 drives ext_rst_n low. A value of 1 in either bit releases that reset.
- R8: The cause register reads bit 1 = 1 after a timeout expiry and bit 0 = 1 after sw_ctl has been 0. Both bits stay set until reset.
- R9: Interrupt control is {int_en[15], int_flag[14], 6'b0, pre[7:0]}. int_flag sets when a strobe leaves exactly pre steps remaining, with pre nonzero. Writing 1 to bit 14 clears int_flag. irq = int_en & int_flag.
- R10: From reset, the power-down counter counts PD_TICKS strobes and then drives pd_n low for exactly one clock. A write to offset 0x8 with bit 0 clear before then disables the counter, and pd_n then stays high.
- R11: A control write that changes the timeout while the timer is running does not change the count in progress. The new value is used at the next service reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock strobe per half-second step |
| lp_mode | input | 1 | Low-power state indication |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| chip_rst | output | 1 | Internal chip reset request, active high |
| ext_rst_n | output | 1 | External reset pin, active low |
| irq | output | 1 | Pretimeout interrupt |
| pd_n | output | 1 | Power-down counter output, active-low pulse |

## Verification
The assertions assume several things about the inputs. tick is a single-clock strobe. The sticky enable, cause and flag bits change only through the bus or the count. Reset is the only event that clears expiry. The stimulus drives tick on one clock in four and never in two adjacent clocks. Each write is one clock wide and is driven after the clock edge. lp_mode changes only between bus accesses. The power-down counter is disabled well before its terminal strobe, so a disable write and a pulse never fall in the same cycle.

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int TW       = 8,
  parameter int PW       = 8,
  parameter int PD_TICKS = 32,
  parameter logic [15:0] KEY_A = 16'h5555,
  parameter logic [15:0] KEY_B = 16'hAAAA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        lp_mode,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        chip_rst,
  output logic        ext_rst_n,
  output logic        irq,
  output logic        pd_n
);
  localparam int CW  = TW + 1;
  localparam int PDW = $clog2(PD_TICKS + 1);

  logic [TW-1:0]  tmo;
  logic           ext_ctl, sw_ctl, rtype, wde, susp, susp_lock;
  logic [CW-1:0]  cnt;
  logic           armed, tout, sw_seen;
  logic           int_en, int_flag;
  logic [PW-1:0]  pre;
  logic           pd_en, pd_pulse;
  logic [PDW-1:0] pd_cnt;

  wire wr_ctl  = bus_we && bus_addr == 4'h0;
  wire wr_svc  = bus_we && bus_addr == 4'h2;
  wire wr_icr  = bus_we && bus_addr == 4'h6;
  wire wr_misc = bus_we && bus_addr == 4'h8;

  wire start   = wr_ctl && bus_wdata[2] && !wde;
  wire svc_ok  = wr_svc && bus_wdata == KEY_B && armed && wde && !tout;
  wire run     = tick && wde && !tout && !(susp && lp_mode);
  wire [CW-1:0] cnt_dec = cnt - 1'b1;
  wire step    = run && cnt != '0;
  wire pre_hit = step && pre != '0 && cnt_dec == CW'(pre);
  wire pd_fire = pd_en && tick && pd_cnt == PDW'(PD_TICKS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo <= '0; ext_ctl <= 1'b1; sw_ctl <= 1'b1; rtype <= 1'b0;
      wde <= 1'b0; susp <= 1'b0; susp_lock <= 1'b0;
    end else if (wr_ctl) begin
      tmo     <= bus_wdata[15:8];
      ext_ctl <= bus_wdata[5];
      sw_ctl  <= bus_wdata[4];
      rtype   <= bus_wdata[3];
      wde     <= wde | bus_wdata[2];
      if (!susp_lock) begin
        susp      <= bus_wdata[0];
        susp_lock <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; tout <= 1'b0;
    end else if (start) begin
      cnt <= CW'(bus_wdata[15:8]) + 1'b1;
    end else if (svc_ok) begin
      cnt <= CW'(tmo) + 1'b1;
    end else if (step) begin
      cnt <= cnt_dec;
      if (cnt_dec == '0) tout <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else if (wr_svc) armed <= (bus_wdata == KEY_A);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_seen <= 1'b0;
    else if (!sw_ctl) sw_seen <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_en <= 1'b0; int_flag <= 1'b0; pre <= '0;
    end else begin
      if (wr_icr) begin
        int_en <= bus_wdata[15];
        pre    <= bus_wdata[PW-1:0];
      end
      if (pre_hit) int_flag <= 1'b1;
      else if (wr_icr && bus_wdata[14]) int_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_en <= 1'b1; pd_cnt <= '0; pd_pulse <= 1'b0;
    end else begin
      pd_pulse <= pd_fire;
      if (pd_fire || (wr_misc && !bus_wdata[0])) pd_en <= 1'b0;
      else if (pd_en && tick) pd_cnt <= pd_cnt + 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      4'h0:    bus_rdata = {tmo, 2'b00, ext_ctl, sw_ctl, rtype, wde, 1'b0, susp};
      4'h4:    bus_rdata = {14'd0, tout, sw_seen};
      4'h6:    bus_rdata = {int_en, int_flag, 14'(pre)};
      4'h8:    bus_rdata = {15'd0, pd_en};
      default: bus_rdata = '0;
    endcase
  end

  assign chip_rst  = (tout && !rtype) || !sw_ctl;
  assign ext_rst_n = ext_ctl && !(tout && rtype);
  assign irq       = int_en && int_flag;
  assign pd_n      = !pd_pulse;

  // R4
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) wde |=> wde);
  // R8
  tout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) tout |=> tout);
  // R2
  expiry_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tout) |-> $past(wde) && $past(tick));
  // R3
  reload_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > $past(cnt)) |-> $past(bus_we));
  // R5
  suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (susp && lp_mode && !bus_we) |=> $stable(cnt));
  // R9
  flag_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_flag) |-> $past(tick));
  // R10
  pd_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n) !pd_n |=> pd_n);
endmodule

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PD_TICKS   = 32;
  localparam int LIMIT      = 20000;

  logic clk = 0, rst_n = 0, tick = 0, lp_mode = 0, bus_we = 0;
  logic [3:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic chip_rst, ext_rst_n, irq, pd_n;

  int checks = 0, fails = 0, cyc = 0, pd_low = 0;
  bit tick_on = 1, done = 0;

  wdog_timer #(.PD_TICKS(PD_TICKS)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .lp_mode(lp_mode),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .chip_rst(chip_rst), .ext_rst_n(ext_rst_n),
    .irq(irq), .pd_n(pd_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  logic [7:0] m_tmo, m_pre;
  logic m_ext, m_sw, m_rt, m_en, m_z, m_zl, m_arm, m_tout, m_seen;
  logic m_ie, m_flag, m_pde, m_pdp;
  int m_cnt, m_pdc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tmo = 0; m_ext = 1; m_sw = 1; m_rt = 0; m_en = 0; m_z = 0; m_zl = 0;
      m_cnt = 0; m_arm = 0; m_tout = 0; m_seen = 0; m_ie = 0; m_flag = 0;
      m_pre = 0; m_pde = 1; m_pdc = 0; m_pdp = 0;
    end else begin
      bit run, hit, clr;
      run = tick && m_en && !m_tout && !(m_z && lp_mode);
      hit = 0;
      if (!m_sw) m_seen = 1;
      if (bus_we && bus_addr == 0 && bus_wdata[2] && !m_en)
        m_cnt = int'(bus_wdata[15:8]) + 1;
      else if (bus_we && bus_addr == 2 && bus_wdata == 16'hAAAA && m_arm && m_en && !m_tout)
        m_cnt = int'(m_tmo) + 1;
      else if (run && m_cnt > 0) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) m_tout = 1;
        if (m_pre != 0 && m_cnt == int'(m_pre)) hit = 1;
      end
      if (bus_we && bus_addr == 2) m_arm = (bus_wdata == 16'h5555);
      clr = bus_we && bus_addr == 6 && bus_wdata[14];
      if (bus_we && bus_addr == 6) begin m_ie = bus_wdata[15]; m_pre = bus_wdata[7:0]; end
      if (hit) m_flag = 1; else if (clr) m_flag = 0;
      m_pdp = 0;
      if (m_pde && tick) begin
        if (m_pdc == PD_TICKS - 1) begin m_pdp = 1; m_pde = 0; end
        else m_pdc = m_pdc + 1;
      end
      if (bus_we && bus_addr == 8 && !bus_wdata[0]) m_pde = 0;
      if (bus_we && bus_addr == 0) begin
        m_tmo = bus_wdata[15:8]; m_ext = bus_wdata[5]; m_sw = bus_wdata[4];
        m_rt = bus_wdata[3]; m_en = m_en | bus_wdata[2];
        if (!m_zl) begin m_z = bus_wdata[0]; m_zl = 1; end
      end
    end
  end

  function automatic logic [15:0] m_rd(input logic [3:0] a);
    case (a)
      0: return {m_tmo, 2'b00, m_ext, m_sw, m_rt, m_en, 1'b0, m_z};
      4: return {14'd0, m_tout, m_seen};
      6: return {m_ie, m_flag, 6'd0, m_pre};
      8: return {15'd0, m_pde};
      default: return 16'd0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) if (rst_n && !done) begin
    chk(chip_rst == ((m_tout && !m_rt) || !m_sw), "R2/R7 chip_rst", chip_rst, (m_tout && !m_rt) || !m_sw);
    chk(ext_rst_n == (m_ext && !(m_tout && m_rt)), "R6/R7 ext_rst_n", ext_rst_n, m_ext && !(m_tout && m_rt));
    chk(irq == (m_ie && m_flag), "R9 irq", irq, m_ie && m_flag);
    chk(pd_n == !m_pdp, "R10 pd_n", pd_n, !m_pdp);
    if (!pd_n) pd_low++;
  end

  always @(posedge clk) begin
    cyc++;
    #2 tick = tick_on && (cyc % 4 == 0);
    if (cyc > LIMIT && !done) begin
      done = 1; fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, LIMIT);
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(posedge clk); #2; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2; bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, input string req);
    @(negedge clk); bus_addr = a; #1;
    chk(bus_rdata == m_rd(a), req, bus_rdata, m_rd(a));
  endtask

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic do_reset(input bit pd_off);
    @(posedge clk); #2; rst_n = 0; lp_mode = 0;
    waitc(2); #2; rst_n = 1; pd_low = 0;
    if (pd_off) wr(8, 16'h0000);
  endtask

  initial begin
    do_reset(0);
    // R1 reset values and offsets
    rd(0, "R1 ctrl"); chk(bus_rdata == 16'h0030, "R1 ctrl reset", bus_rdata, 16'h0030);
    rd(2, "R1 svc"); rd(4, "R1 cause"); rd(6, "R1 icr"); rd(8, "R1 misc"); rd(10, "R1 hole");
    // R10 power-down pulse once
    waitc(4 * PD_TICKS + 20);
    chk(pd_low == 1, "R10 one pulse", pd_low, 1);
    rd(8, "R10 misc after");

    // R2 R4 R8 expiry, enable cannot be cleared
    do_reset(1);
    wr(0, 16'h0534); waitc(8); wr(0, 16'h0530);
    rd(0, "R4 enable readback");
    waitc(40);
    chk(chip_rst == 1, "R2 expired", chip_rst, 1);
    rd(4, "R8 cause tout"); chk(bus_rdata == 16'h0002, "R8 cause value", bus_rdata, 2);

    // R10 disabled
    do_reset(1); waitc(4 * PD_TICKS + 40);
    chk(pd_low == 0, "R10 disabled", pd_low, 0);

    // R3 good services keep alive
    do_reset(1);
    wr(0, 16'h0734);
    for (int i = 0; i < 5; i++) begin waitc(20); wr(2, 16'h5555); wr(2, 16'hAAAA); end
    chk(chip_rst == 0, "R3 kept alive", chip_rst, 0);
    wr(2, 16'h5555); wr(2, 16'h1234); wr(2, 16'hAAAA);
    waitc(40);
    chk(chip_rst == 1, "R3 broken sequence", chip_rst, 1);

    // R11 new timeout only at reload
    do_reset(1);
    wr(0, 16'h0734); waitc(4); wr(0, 16'h0230); waitc(12);
    chk(chip_rst == 0, "R11 old count kept", chip_rst, 0);
    wr(2, 16'h5555); wr(2, 16'hAAAA); waitc(20);
    chk(chip_rst == 1, "R11 new count used", chip_rst, 1);

    // R6 external-only reset
    do_reset(1);
    wr(0, 16'h073C); waitc(45);
    chk(ext_rst_n == 0 && chip_rst == 0, "R6 external only", {ext_rst_n, chip_rst}, 0);

    // R5 suspend write-once and hold
    do_reset(1);
    wr(0, 16'h0735); lp_mode = 1; waitc(100);
    chk(chip_rst == 0, "R5 held", chip_rst, 0);
    wr(0, 16'h0734); rd(0, "R5 readback");
    chk(bus_rdata[0] == 1, "R5 write-once", bus_rdata[0], 1);
    lp_mode = 0; waitc(45);
    chk(chip_rst == 1, "R5 resumes", chip_rst, 1);

    // R9 pretimeout interrupt
    do_reset(1);
    wr(6, 16'h8003); wr(0, 16'h0934); waitc(34);
    chk(irq == 1, "R9 irq raised", irq, 1);
    rd(6, "R9 icr read");
    wr(6, 16'hC003); waitc(1);
    chk(irq == 0, "R9 cleared", irq, 0);

    // R7 software reset controls
    do_reset(1);
    wr(0, 16'h0020); waitc(2);
    chk(chip_rst == 1, "R7 sw reset", chip_rst, 1);
    rd(4, "R8 cause sw");
    do_reset(1);
    wr(0, 16'h0010); waitc(2);
    chk(ext_rst_n == 0 && chip_rst == 0, "R7 ext drive", {ext_rst_n, chip_rst}, 0);
    wr(0, 16'h0030); waitc(2);
    chk(ext_rst_n == 1 && chip_rst == 0, "R7 released", {ext_rst_n, chip_rst}, 2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule